// File: doc/BRIEF.md
# Presence-Detect EEPROM Dump Sequencer

This block is a fixed-function two-wire bus master. It reads out the configuration EEPROM that sits on a memory module. One start pulse launches the dump. The block first runs a short write transaction that sets the EEPROM's internal pointer to zero. It then opens a read transaction and pulls every byte out in one sequential burst. Each received byte is presented for one cycle on a strobe, together with its index.

While the bytes stream past, four configuration fields are captured into output registers:

- the memory type,
- the bank count,
- the low byte of the module data width,
- the mask of supported burst lengths.

These registers stay valid until the next start pulse. The bus lines are open drain: the block only pulls SCL or SDA low, or releases them. Bit timing comes from a divider of the system clock, with one bit split into four equal quarters.

If the EEPROM fails to acknowledge the write address, the pointer byte or the read address, the block stops the sequence. It then issues a STOP and raises a sticky error flag.

Top module: `spd_reader`

## Requirements
- R1: After reset, and whenever idle, both line enables `sclOe` and `sdaOe` are 0 (lines released). After reset, `busy`, `done`, `error` and all four field outputs are 0.
- R2: The first transaction is START, then address byte 0xA0 (7-bit address 0x50, write bit 0), then pointer byte 0x00, then STOP. Each byte is sent MSB first, and the slave's acknowledge is sampled after each byte.
- R3: The second transaction is START, then 0xA1 (read bit 1), then NUM_BYTES data bytes, then STOP. The master acknowledges (SDA low in the ninth bit) every data byte except the last, which it answers with a NACK (SDA released).
- R4: SDA changes only while SCL is low, except at a START (SDA falls while SCL is high) and at a STOP (SDA rises while SCL is high). A full dump therefore shows exactly two STARTs and two STOPs.
- R5: Each received byte (MSB first) appears on `byteData` with `byteValid` high for exactly one cycle. `byteIndex` counts 0, 1, … NUM_BYTES-1 in order.
- R6: The byte at index 2 is latched into `memType`, index 5 into `bankCount`, index 6 into `widthLo` and index 16 into `burstMask`. In that mask, bit 7 means full page and bits 3..0 mean burst lengths 8, 4, 2 and 1. All four are cleared by an accepted start.
- R7: A NACK on the write address, the pointer or the read address ends the sequence with a STOP. No data bytes are strobed, `done` rises and `error` is set. `error` holds until the next accepted start.
- R8: `done` rises after the final STOP and stays high until an accepted start. An accepted start clears `done` and `error`.
- R9: A start pulse while `busy` is high is ignored. The running dump continues with no new START on the bus.
- R10: Within a byte, consecutive SCL rising edges are 4·QTR_DIV system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that launches a dump when idle |
| sdaIn | input | 1 | Sampled level of the SDA line |
| sclOe | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (level) |
| error | output | 1 | Sticky acknowledge failure |
| byteValid | output | 1 | One-cycle strobe per received byte |
| byteIndex | output | IDX_W (8) | Index of the strobed byte |
| byteData | output | 8 | Value of the strobed byte |
| memType | output | 8 | Captured memory type (index 2) |
| bankCount | output | 8 | Captured bank count (index 5) |
| widthLo | output | 8 | Captured data width low byte (index 6) |
| burstMask | output | 8 | Captured burst length mask (index 16) |

## Verification
The hardest situations to reach are the abort paths, because a missing acknowledge only exists on a bus that a slave shares with the master. The bench therefore models the EEPROM behaviourally on the open-drain lines. It decodes START and STOP, shifts in the address and pointer bytes, and drives data back from an arithmetic content pattern. The model can be told to withhold its acknowledge on the write address, the pointer or the read address. Each of the three aborts is run in turn, followed by a clean dump with a different pattern, which shows that the error clears.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START_W,
    S_ADDR_W,
    S_PTR,
    S_STOP_W,
    S_START_R,
    S_ADDR_R,
    S_READ,
    S_STOP_END
  } seqState_t;

  localparam logic [1:0] LD_ADDR_W = 2'd0;
  localparam logic [1:0] LD_PTR    = 2'd1;
  localparam logic [1:0] LD_ADDR_R = 2'd2;

  localparam int FIELD_CNT = 4;

  // control-to-datapath strobes
  typedef struct packed {
    logic       loadTx;
    logic [1:0] loadSel;
    logic       shiftTx;
    logic       shiftRx;
    logic       rxBit;
    logic       byteDone;
    logic       clearAll;
  } dpCtrl_t;

  // byte index captured by each field slot
  function automatic int fieldPos(input int k);
    case (k)
      0:       return 2;   // memory type
      1:       return 5;   // bank count
      2:       return 6;   // data width, low byte
      default: return 16;  // burst length mask
    endcase
  endfunction

endpackage

// File: rtl/spd_datapath.sv
module spd_datapath
  import spd_pkg::*;
#(
  parameter int       NUM_BYTES = 256,
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int       IDX_W     = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCtrl_t                       ctl,
  output logic                          txBit,
  output logic                          lastByte,
  output logic                          byteValid,
  output logic [IDX_W-1:0]              byteIndex,
  output logic [7:0]                    byteData,
  output logic [FIELD_CNT-1:0][7:0]     fields
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  logic [7:0]       txShift;
  logic [7:0]       rxShift;
  logic [IDX_W-1:0] byteIdx;
  logic [7:0]       loadVal;

  always_comb begin
    case (ctl.loadSel)
      LD_ADDR_W: loadVal = {DEV_ADDR, 1'b0};
      LD_ADDR_R: loadVal = {DEV_ADDR, 1'b1};
      default:   loadVal = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= 8'hFF;
    end else if (ctl.loadTx) begin
      txShift <= loadVal;
    end else if (ctl.shiftTx) begin
      txShift <= {txShift[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (ctl.shiftRx) begin
      rxShift <= {rxShift[6:0], ctl.rxBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
    end else if (ctl.clearAll) begin
      byteIdx <= '0;
    end else if (ctl.byteDone) begin
      byteIdx <= byteIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteValid <= 1'b0;
      byteIndex <= '0;
      byteData  <= '0;
    end else begin
      byteValid <= ctl.byteDone;
      if (ctl.byteDone) begin
        byteIndex <= byteIdx;
        byteData  <= rxShift;
      end
    end
  end

  for (genvar k = 0; k < FIELD_CNT; k++) begin : g_field
    localparam logic [IDX_W-1:0] POS = IDX_W'(fieldPos(k));
    logic [7:0] capQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capQ <= '0;
      end else if (ctl.clearAll) begin
        capQ <= '0;
      end else if (ctl.byteDone && byteIdx == POS) begin
        capQ <= rxShift;
      end
    end
    assign fields[k] = capQ;
  end

  assign txBit    = txShift[7];
  assign lastByte = (byteIdx == LAST_IDX);

endmodule

// File: rtl/spd_ctrl.sv
module spd_ctrl
  import spd_pkg::*;
#(
  parameter int QTR_DIV = 125
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    sdaIn,
  input  logic    txBit,
  input  logic    lastByte,
  output dpCtrl_t ctl,
  output logic    sclOe,
  output logic    sdaOe,
  output logic    busy,
  output logic    done,
  output logic    error
);

  localparam int DIV_W = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(QTR_DIV - 1);

  seqState_t  state;
  logic [DIV_W-1:0] divCnt;
  logic [1:0] qtr;
  logic [3:0] bitCnt;
  logic       ackBad;
  logic       doneQ;
  logic       errQ;

  logic opStart, opStop, sending, reading;
  logic tick, sample, bitEnd, ackBit, startAccept;

  always_comb begin
    opStart     = (state == S_START_W) || (state == S_START_R);
    opStop      = (state == S_STOP_W) || (state == S_STOP_END);
    sending     = (state == S_ADDR_W) || (state == S_PTR) || (state == S_ADDR_R);
    reading     = (state == S_READ);
    busy        = (state != S_IDLE);
    startAccept = start && !busy;
    tick        = busy && (divCnt == DIV_LAST);
    sample      = tick && (qtr == 2'd1) && (sending || reading);
    bitEnd      = tick && (qtr == 2'd3);
    ackBit      = (bitCnt == 4'd8);
  end

  // line drive per quarter
  always_comb begin
    if (opStart) begin
      sclOe = (qtr == 2'd3);
      sdaOe = (qtr >= 2'd2);
    end else if (opStop) begin
      sclOe = (qtr == 2'd0);
      sdaOe = (qtr <= 2'd1);
    end else if (sending) begin
      sclOe = (qtr == 2'd0) || (qtr == 2'd3);
      sdaOe = !ackBit && !txBit;
    end else if (reading) begin
      sclOe = (qtr == 2'd0) || (qtr == 2'd3);
      sdaOe = ackBit && !lastByte;
    end else begin
      sclOe = 1'b0;
      sdaOe = 1'b0;
    end
  end

  // strobes to the datapath
  always_comb begin
    ctl          = '0;
    ctl.clearAll = startAccept;
    ctl.rxBit    = sdaIn;
    ctl.shiftRx  = sample && reading && !ackBit;
    ctl.shiftTx  = bitEnd && sending && !ackBit;
    ctl.byteDone = bitEnd && reading && ackBit;
    ctl.loadTx   = bitEnd && ((state == S_START_W) || (state == S_START_R) ||
                              (state == S_ADDR_W && ackBit && !ackBad));
    if (state == S_START_R)     ctl.loadSel = LD_ADDR_R;
    else if (state == S_ADDR_W) ctl.loadSel = LD_PTR;
    else                        ctl.loadSel = LD_ADDR_W;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      divCnt <= '0;
      qtr    <= '0;
      bitCnt <= '0;
      ackBad <= 1'b0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else if (startAccept) begin
      state  <= S_START_W;
      divCnt <= '0;
      qtr    <= '0;
      bitCnt <= '0;
      ackBad <= 1'b0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else if (busy) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) qtr <= qtr + 1'b1;
      if (sample && sending && ackBit) ackBad <= sdaIn;
      if (bitEnd) begin
        case (state)
          S_START_W: begin
            state  <= S_ADDR_W;
            bitCnt <= '0;
          end
          S_ADDR_W, S_PTR, S_ADDR_R: begin
            if (!ackBit) begin
              bitCnt <= bitCnt + 1'b1;
            end else begin
              bitCnt <= '0;
              if (ackBad) begin
                errQ  <= 1'b1;
                state <= S_STOP_END;
              end else if (state == S_ADDR_W) begin
                state <= S_PTR;
              end else if (state == S_PTR) begin
                state <= S_STOP_W;
              end else begin
                state <= S_READ;
              end
            end
          end
          S_STOP_W:  state <= S_START_R;
          S_START_R: begin
            state  <= S_ADDR_R;
            bitCnt <= '0;
          end
          S_READ: begin
            if (!ackBit) begin
              bitCnt <= bitCnt + 1'b1;
            end else begin
              bitCnt <= '0;
              if (lastByte) state <= S_STOP_END;
            end
          end
          S_STOP_END: begin
            state <= S_IDLE;
            doneQ <= 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign done  = doneQ;
  assign error = errQ;

endmodule

// File: rtl/spd_reader.sv
module spd_reader
  import spd_pkg::*;
#(
  parameter int         QTR_DIV   = 125,
  parameter int         NUM_BYTES = 256,
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  localparam int        IDX_W     = $clog2(NUM_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             sdaIn,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             byteValid,
  output logic [IDX_W-1:0] byteIndex,
  output logic [7:0]       byteData,
  output logic [7:0]       memType,
  output logic [7:0]       bankCount,
  output logic [7:0]       widthLo,
  output logic [7:0]       burstMask
);

  dpCtrl_t                      dpCtl;
  logic                         txBit;
  logic                         lastByte;
  logic [FIELD_CNT-1:0][7:0]    fields;

  spd_ctrl #(.QTR_DIV(QTR_DIV)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .sdaIn    (sdaIn),
    .txBit    (txBit),
    .lastByte (lastByte),
    .ctl      (dpCtl),
    .sclOe    (sclOe),
    .sdaOe    (sdaOe),
    .busy     (busy),
    .done     (done),
    .error    (error)
  );

  spd_datapath #(
    .NUM_BYTES (NUM_BYTES),
    .DEV_ADDR  (DEV_ADDR),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (dpCtl),
    .txBit     (txBit),
    .lastByte  (lastByte),
    .byteValid (byteValid),
    .byteIndex (byteIndex),
    .byteData  (byteData),
    .fields    (fields)
  );

  assign memType   = fields[0];
  assign bankCount = fields[1];
  assign widthLo   = fields[2];
  assign burstMask = fields[3];

endmodule

// File: rtl/spd_reader_chk.sv
module spd_reader_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             sclOe,
  input logic             sdaOe,
  input logic             busy,
  input logic             done,
  input logic             error,
  input logic             byteValid,
  input logic [IDX_W-1:0] byteIndex,
  input logic [7:0]       byteData,
  input logic [7:0]       memType
);

  logic [IDX_W-1:0] expIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  expIdx <= '0;
    else if (start && !busy)    expIdx <= '0;
    else if (byteValid)         expIdx <= expIdx + 1'b1;
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclOe && !sdaOe)); // R1

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid); // R5

  AST_INDEX_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> (byteIndex == expIdx)); // R5

  AST_TYPE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteIndex == IDX_W'(2)) |-> (memType == byteData)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (error && !(start && !busy)) |=> error); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8

endmodule

bind spd_reader spd_reader_chk #(.IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .sclOe     (sclOe),
  .sdaOe     (sdaOe),
  .busy      (busy),
  .done      (done),
  .error     (error),
  .byteValid (byteValid),
  .byteIndex (byteIndex),
  .byteData  (byteData),
  .memType   (memType)
);

// File: tb/spd_reader_tb.sv
module spd_reader_tb_top;

  localparam int QTR   = 3;
  localparam int NB    = 256;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic sclOe, sdaOe, busy, done, error, byteValid;
  logic [7:0] byteIndex, byteData, memType, bankCount, widthLo, burstMask;
  logic slvLow = 1'b0;

  wire sclLine = !sclOe;
  wire sdaLine = !(sdaOe || slvLow);

  always #10 clk = !clk;

  spd_reader #(.QTR_DIV(QTR), .NUM_BYTES(NB)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy), .done(done), .error(error),
    .byteValid(byteValid), .byteIndex(byteIndex), .byteData(byteData),
    .memType(memType), .bankCount(bankCount), .widthLo(widthLo),
    .burstMask(burstMask)
  );

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  int seed = 0;
  int nackSel = 0;

  function automatic logic [7:0] memFn(input int s, input int i);
    return 8'(((i * 29) + s) ^ (i >> 2));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave model state and bus log
  int slvMode = 0;   // 0 idle, 1 receive, 2 transmit, 3 ignore
  int bitPos = 0;
  int byteNum = 0;
  int ptr = 0;
  bit isRead = 0;
  bit lastAck = 0;
  logic [7:0] shIn = 0;
  logic [7:0] curByte = 0;
  logic prevScl = 1'b1;
  logic prevSda = 1'b1;
  int wrLog [8];
  int wrCnt = 0, startCnt = 0, stopCnt = 0, mAck = 0, mNack = 0, nackAt = -1;
  int lastRise = 0, periodErr = 0, dutBytes = 0;

  always @(negedge clk) begin
    logic scl, sda;
    bit ackIt;
    cyc++;
    scl = sclLine;
    sda = sdaLine;
    if (prevScl && scl && prevSda && !sda) begin
      startCnt++;
      slvMode = 1; bitPos = -1; byteNum = 0; isRead = 0; slvLow = 1'b0;
    end else if (prevScl && scl && !prevSda && sda) begin
      stopCnt++;
      slvMode = 0; slvLow = 1'b0;
    end else if (!prevScl && scl && slvMode != 0) begin
      if (bitPos >= 1 && bitPos <= 8 && (cyc - lastRise) != 4 * QTR) periodErr++;
      lastRise = cyc;
      if (slvMode == 1 && bitPos < 8) shIn = {shIn[6:0], sda};
      if (slvMode == 2 && bitPos == 8) begin
        lastAck = !sda;
        if (!sda) mAck++;
        else begin mNack++; nackAt = ptr - 1; end
      end
    end else if (prevScl && !scl && slvMode != 0) begin
      if (bitPos == 7) begin
        bitPos = 8;
        if (slvMode == 1) begin
          if (wrCnt < 8) wrLog[wrCnt] = int'(shIn);
          wrCnt++;
          ackIt = (byteNum != 0) || (shIn[7:1] == 7'h50);
          if (byteNum == 0) begin
            isRead = shIn[0];
            if ((shIn == 8'hA0 && nackSel == 1) || (shIn == 8'hA1 && nackSel == 3)) ackIt = 0;
          end
          if (byteNum == 1) begin
            ptr = int'(shIn);
            if (nackSel == 2) ackIt = 0;
          end
          byteNum++;
          slvLow = ackIt;
          if (!ackIt) slvMode = 3;
        end else if (slvMode == 2) begin
          slvLow = 1'b0;
        end
      end else if (bitPos == 8) begin
        bitPos = 0;
        slvLow = 1'b0;
        if ((slvMode == 1 && isRead) || (slvMode == 2 && lastAck)) begin
          slvMode = 2; isRead = 0;
          curByte = memFn(seed, ptr); ptr++;
          slvLow = !curByte[7];
        end else if (slvMode == 2) begin
          slvMode = 3;
        end
      end else begin
        bitPos++;
        if (slvMode == 2) slvLow = !curByte[7 - bitPos];
      end
    end
    prevScl = scl;
    prevSda = sda;
  end

  // per-byte output check: R5
  always @(negedge clk) begin
    if (byteValid) begin
      check(int'(byteIndex) == dutBytes && byteData == memFn(seed, dutBytes),
            "R5 byte index/data", int'(byteData), int'(memFn(seed, dutBytes)));
      dutBytes++;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  task automatic waitDone();
    while (!done) begin
      @(negedge clk);
      if (cyc > LIMIT) begin
        checks++; errs++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        finish_run();
      end
    end
  endtask

  task automatic launch(input int nk, input int sd);
    nackSel = nk; seed = sd;
    wrCnt = 0; startCnt = 0; stopCnt = 0; mAck = 0; mNack = 0; nackAt = -1;
    periodErr = 0; dutBytes = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done && busy, "R8 done cleared by start", int'(done), 0);
    check(!error, "R8 error cleared by start", int'(error), 0);
  endtask

  task automatic checkFull(input string tag);
    check(wrCnt == 3 && wrLog[0] == 'hA0 && wrLog[1] == 'h00 && wrLog[2] == 'hA1,
          "R2 bytes written", wrLog[0], 'hA0);
    check(startCnt == 2 && stopCnt == 2, "R4 START/STOP count", startCnt * 10 + stopCnt, 22);
    check(mAck == NB - 1, "R3 master acks", mAck, NB - 1);
    check(mNack == 1 && nackAt == NB - 1, "R3 final NACK position", nackAt, NB - 1);
    check(dutBytes == NB, "R5 strobe count", dutBytes, NB);
    check(periodErr == 0, "R10 SCL period", periodErr, 0);
    check(memType == memFn(seed, 2), "R6 memType", int'(memType), int'(memFn(seed, 2)));
    check(bankCount == memFn(seed, 5), "R6 bankCount", int'(bankCount), int'(memFn(seed, 5)));
    check(widthLo == memFn(seed, 6), "R6 widthLo", int'(widthLo), int'(memFn(seed, 6)));
    check(burstMask == memFn(seed, 16), "R6 burstMask", int'(burstMask), int'(memFn(seed, 16)));
    check(done && !error && !busy, {"R8 done after dump ", tag}, int'(error), 0);
  endtask

  task automatic checkAbort(input int nk, input int expWr, input int expStarts);
    check(error && done, "R7 error and done after NACK", int'(error), 1);
    check(wrCnt == expWr, "R7 bytes sent before abort", wrCnt, expWr);
    check(startCnt == expStarts && stopCnt == expStarts, "R7 STOP issued",
          stopCnt, expStarts);
    check(dutBytes == 0, "R7 no data strobes", dutBytes, 0);
    check(memType == 0 && burstMask == 0, "R6 fields cleared at start", int'(memType), 0);
    repeat (50) @(negedge clk);
    check(error && !busy && !sclOe && !sdaOe, "R7 error sticky, lines released",
          int'(error), 1);
    if (nk != 0) nackSel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!sclOe && !sdaOe, "R1 lines released after reset", int'(sclOe), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !error, "R1 status after reset", int'(busy | done | error), 0);
    check(memType == 0 && bankCount == 0 && widthLo == 0 && burstMask == 0,
          "R1 fields after reset", int'(memType), 0);

    // full dump, with a stray start mid-run (R9)
    launch(0, 17);
    repeat (1500) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(busy, "R9 stray start ignored", int'(busy), 1);
    waitDone();
    checkFull("A");

    launch(1, 40);
    waitDone();
    checkAbort(1, 1, 1);

    launch(2, 40);
    waitDone();
    checkAbort(2, 2, 1);

    launch(3, 40);
    waitDone();
    checkAbort(3, 3, 2);

    // clean dump after errors, new content
    launch(0, 201);
    waitDone();
    checkFull("B");

    finish_run();
  end

endmodule